// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block reads one 8-bit sample from an external converter that has a three-wire serial interface: an active-low chip select, a serial clock and a serial data line. A one-cycle request on `start_i` begins a frame. The block first holds the serial clock low and asserts chip select. It then issues two complete clock pulses and captures nothing during them. Eight more clock pulses follow, and one data bit is taken after each falling edge. Chip select is released as soon as the last bit is in.

The serial clock runs well below the system clock. Each high phase and each low phase lasts `HALF_PERIOD` system clocks. A finished conversion raises `done_o` for a single cycle. The assembled byte stays on `result_o` until the next frame completes. A request that arrives while a frame is running is dropped. A host starts frames one at a time and waits for the done pulse before it sends the next request.

Top module: `sadc_reader`

## Requirements
- R1: After reset `cs_n_o` is 1, `sclk_o` is 0, `result_o` is 0, and both `busy_o` and `done_o` are 0.
- R2: A `start_i` high while idle drives `cs_n_o` to 0 and sets `busy_o` in the next cycle, with `sclk_o` still 0.
- R3: Every serial clock phase, high or low, lasts exactly `HALF_PERIOD` system clocks, and each frame contains exactly ten rising edges of `sclk_o`. The first rising edge comes after a low phase of that same length that follows the fall of chip select.
- R4: The data line is not captured during the first two clock pulses of a frame, so the values it carries then do not affect `result_o`.
- R5: One bit is captured at the end of the low phase that follows each of pulses three to ten. Captured bits enter from the LSB side with a left shift, so the first captured bit becomes bit 7 of the result.
- R6: `cs_n_o` returns to 1 in the same cycle that `done_o` is asserted. This is `21*HALF_PERIOD` cycles after the clock edge that accepted the request.
- R7: `done_o` is high for exactly one cycle per frame, and `result_o` already carries the new byte in that cycle.
- R8: `result_o` changes only in a cycle where `done_o` is high. Between completions, including during a later frame, it holds the last byte.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. It neither restarts nor lengthens the frame and produces no extra completion.
- R10: `sclk_o` is 0 whenever `cs_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse when the byte is ready |
| result_o | output | 8 | Last assembled conversion byte |

## Verification
Two situations are hard to reach from the ports: a second request arriving in the middle of a frame, and junk on the data line during the lead-in pulses. The bench's converter model drives a 1 on the data line throughout the lead-in, so a frame that should read 0x00 exposes any early capture. In one frame the bench also fires an extra request partway through. It then confirms that the frame length, the count of completions and the delivered byte are all unchanged.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Count of phases in a frame: one settling low phase plus a high and
    // a low phase for each pulse.
    function automatic int unsigned frame_phases(input int unsigned lead, input int unsigned bits);
        return 1 + 2 * (lead + bits);
    endfunction

    // Width of a counter that holds values 0..n-1, at least one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sadc_phase_timer.sv
module sadc_phase_timer #(
    parameter int unsigned HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic expire_o
);
    import sadc_pkg::*;

    localparam int unsigned CW = cnt_width(HALF_PERIOD);
    localparam logic [CW-1:0] RELOAD = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (run_i) begin
            if (cnt_q == '0) begin
                cnt_q <= RELOAD;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expire_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/sadc_sequencer.sv
module sadc_sequencer #(
    parameter int unsigned LEAD_PULSES = 2,
    parameter int unsigned DATA_BITS   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic expire_i,
    output logic load_o,
    output logic run_o,
    output logic cs_n_o,
    output logic sclk_o,
    output logic sample_o,
    output logic last_o,
    output logic done_o
);
    import sadc_pkg::*;

    localparam int unsigned NPH          = frame_phases(LEAD_PULSES, DATA_BITS);
    localparam int unsigned PW           = cnt_width(NPH);
    localparam logic [PW-1:0] LAST_PH    = PW'(NPH - 1);
    localparam logic [PW-1:0] FIRST_SAMP = PW'(2 * (LEAD_PULSES + 1));

    seq_state_t    state_q;
    logic [PW-1:0] ph_q;
    logic          cs_n_q;
    logic          sclk_q;
    logic          done_q;

    assign load_o   = (state_q == SEQ_IDLE) && start_i;
    assign run_o    = (state_q == SEQ_RUN);
    assign last_o   = run_o && expire_i && (ph_q == LAST_PH);
    assign sample_o = run_o && expire_i && !ph_q[0] && (ph_q >= FIRST_SAMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            ph_q    <= '0;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        state_q <= SEQ_RUN;
                        ph_q    <= '0;
                        sclk_q  <= 1'b0;
                        cs_n_q  <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (expire_i) begin
                        if (ph_q == LAST_PH) begin
                            state_q <= SEQ_IDLE;
                            cs_n_q  <= 1'b1;
                            sclk_q  <= 1'b0;
                            done_q  <= 1'b1;
                        end else begin
                            ph_q   <= ph_q + 1'b1;
                            sclk_q <= ~ph_q[0];
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign cs_n_o = cs_n_q;
    assign sclk_o = sclk_q;
    assign done_o = done_q;

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_i,
    input  logic                 last_i,
    input  logic                 sdata_i,
    output logic [DATA_BITS-1:0] result_o
);
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] result_q;
    logic [DATA_BITS-1:0] shift_next;

    generate
        if (DATA_BITS > 1) begin : g_wide
            assign shift_next = {shift_q[DATA_BITS-2:0], sdata_i};
        end else begin : g_single
            assign shift_next = sdata_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q  <= '0;
            result_q <= '0;
        end else begin
            if (sample_i) begin
                shift_q <= shift_next;
            end
            if (last_i) begin
                result_q <= shift_next;
            end
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
    parameter int unsigned HALF_PERIOD = 4,
    parameter int unsigned LEAD_PULSES = 2,
    parameter int unsigned DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 sdata_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] result_o
);
    logic tmr_load;
    logic tmr_run;
    logic tmr_expire;
    logic smp;
    logic last;

    sadc_phase_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .run_i    (tmr_run),
        .expire_o (tmr_expire)
    );

    sadc_sequencer #(.LEAD_PULSES(LEAD_PULSES), .DATA_BITS(DATA_BITS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .expire_i (tmr_expire),
        .load_o   (tmr_load),
        .run_o    (tmr_run),
        .cs_n_o   (cs_n_o),
        .sclk_o   (sclk_o),
        .sample_o (smp),
        .last_o   (last),
        .done_o   (done_o)
    );

    sadc_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sample_i (smp),
        .last_i   (last),
        .sdata_i  (sdata_i),
        .result_o (result_o)
    );

    assign busy_o = tmr_run;

endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 cs_n_o,
    input logic                 sclk_o,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [DATA_BITS-1:0] result_o
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (!cs_n_o && !sclk_o && busy_o));

    // R6
    release_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n_o && !busy_o));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> done_o);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o));

    // R10
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

endmodule

bind sadc_reader sadc_reader_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .cs_n_o   (cs_n_o),
    .sclk_o   (sclk_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/sadc_reader_tb.sv
module sadc_reader_tb;
    localparam int H = 4;
    localparam int FRAME = 21 * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic sdata_i = 1'b1;
    logic cs_n_o, sclk_o, busy_o, done_o;
    logic [7:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int start_mark = 0;
    int done_cnt = 0;
    int rises = 0;
    bit finished = 0;
    logic [7:0] model_byte = 8'h00;
    logic [7:0] exp_q[$];
    logic [7:0] last_res = 8'h00;

    always #10 clk = ~clk;

    sadc_reader #(.HALF_PERIOD(H)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .sdata_i(sdata_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .done_o(done_o), .result_o(result_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: lead-in pulses carry junk (1), then MSB first.
    always @(negedge cs_n_o) begin
        rises = 0;
        sdata_i = 1'b1;
    end
    always @(posedge sclk_o) begin
        if (rises < 2) sdata_i = 1'b1;
        else sdata_i = model_byte[9 - rises];
        rises = rises + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done_o) begin
            logic [7:0] e;
            done_cnt++;
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(result_o == e, "R5 result", result_o, e);
                check(cs_n_o == 1'b1, "R6 cs released", cs_n_o, 1);
                check(cyc - start_mark == FRAME, "R6 frame length", cyc - start_mark, FRAME);
                check(rises == 10, "R3 sclk rises", rises, 10);
                last_res = e;
            end
        end
    end

    task automatic frame(input logic [7:0] b, input bit extra_start);
        model_byte = b;
        exp_q.push_back(b);
        @(negedge clk);
        start_i = 1'b1;
        start_mark = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        check(!cs_n_o && !sclk_o && busy_o, "R2 accept", {cs_n_o, sclk_o, busy_o}, 3'b001);
        // R3: sclk stays low for H cycles after cs falls
        repeat (H - 1) @(negedge clk);
        check(sclk_o == 1'b0, "R3 settle low", sclk_o, 0);
        @(negedge clk);
        check(sclk_o == 1'b1, "R3 first rise", sclk_o, 1);
        repeat (20) @(negedge clk);
        // R8: old result held mid-frame
        check(result_o == last_res, "R8 hold in frame", result_o, last_res);
        if (extra_start) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        // R1
        check(cs_n_o == 1 && sclk_o == 0 && result_o == 0 && !busy_o && !done_o,
              "R1 reset state", {cs_n_o, sclk_o, busy_o, done_o, result_o}, 12'h800);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(cs_n_o == 1 && result_o == 0, "R1 idle after reset", result_o, 0);
        frame(8'hA5, 0);
        frame(8'h00, 0);   // R4: lead-in junk of 1 must not appear
        check(result_o == 8'h00, "R4 lead-in ignored", result_o, 0);
        frame(8'hFF, 0);
        frame(8'h01, 0);   // R5 LSB side
        frame(8'h80, 0);   // R5 first bit to MSB
        d0 = done_cnt;
        frame(8'h3C, 1);   // R9 extra start mid-frame
        repeat (100) @(negedge clk);
        check(done_cnt == d0 + 1, "R9 one completion", done_cnt, d0 + 1);
        check(!busy_o && cs_n_o, "R9 no restart", busy_o, 0);
        // R8/R7: result held while idle
        check(result_o == 8'h3C, "R8 hold idle", result_o, 8'h3C);
        check(!done_o, "R7 done pulse ended", done_o, 0);
        check(exp_q.size() == 0, "R7 all frames completed", exp_q.size(), 0);
        summary();
    end

endmodule